// File: doc/BRIEF.md
# Byte/Word ALU with Status Flags

This block is the arithmetic and logic unit of a small 16-bit controller core. It is purely combinational. It takes two operand words, a four-bit operation code, a byte/word size select and the current status word. From these it produces a result, a write-enable for the destination and an updated status word. Eleven two-operand operations are covered: binary add and subtract with and without carry, compare, decimal add, and the bitwise and, test, clear, set and exclusive-or. Four one-operand operations are also covered: rotate through carry, arithmetic shift right, byte swap and sign extension. The first operand (`opA`) is the destination value. Subtraction and compare compute `opA - opB`.

Each operation has a mask that names the flags it affects: carry, zero, negative and overflow. The newly computed flags are merged into the status word only through that mask. Every other status bit passes through unchanged. The same unit also evaluates the conditional-jump predicate for the instruction decoder, using the incoming status word.

Top module: `alu_core`

## Requirements
- R1: Operation codes on `opCode` are ADD=0, ADDC=1, SUB=2, SUBC=3, CMP=4, DADD=5, AND=6, BIT=7, BIC=8, BIS=9, XOR=10, RRC=11, RRA=12, SWPB=13, SXT=14; code 15 is undefined. `byteMode`=1 selects byte size (bits 7:0), 0 selects word size. Status bits are C at bit 0, Z at bit 1, N at bit 2 and V at bit 8. All other status bits pass from `statusIn` to `statusOut` unchanged.
- R2: ADD yields opA+opB and ADDC yields opA+opB+C. C is the carry out of the operand size. V is set when both addends have the same sign and the result's sign differs from it.
- R3: SUB and CMP yield opA+~opB+1, and SUBC yields opA+~opB+C, each taken within the size. C is the carry out, so C=1 means no borrow. V is set when the signs of opA and opB differ and the result's sign differs from opA. CMP drives this difference on `result` but does not write it.
- R4: For every operation that updates N and Z, N equals the result's most significant bit at the operation's size, and Z is set exactly when all result bits within that size are zero.
- R5: DADD adds opA, opB and C digit by digit as packed BCD: two digits at byte size, four at word size. C is set when the decimal sum exceeds 99 (byte) or 9999 (word). V is left unchanged. Operands are assumed to be valid BCD.
- R6: AND and BIT yield opA&opB, set C when the result is nonzero and clear V. BIT does not write its result.
- R7: XOR yields opA^opB and sets C when the result is nonzero. V is set exactly when both operands have their sign bit set at the operation's size.
- R8: BIC yields opA&~opB and BIS yields opA|opB. Neither changes any status bit.
- R9: RRC shifts opA right by one, puts the old C into the most significant bit of the size, and puts the old bit 0 into C. RRA shifts right keeping the sign bit, and also puts the old bit 0 into C. Both clear V.
- R10: SWPB and SXT always work on the full word, whatever `byteMode` is. SWPB exchanges the two bytes and leaves all status bits unchanged. SXT copies bit 7 into bits 15:8, sets N and Z from the word result, sets C when the result is nonzero and clears V.
- R11: In byte mode, every operation except SWPB and SXT drives zero on result bits 15:8.
- R12: `jumpTaken` is evaluated on `statusIn` for condition code `condCode`: 0 Z=0, 1 Z=1, 2 C=0, 3 C=1, 4 N=1, 5 N equal to V, 6 N different from V, 7 always.
- R13: `writeEn` is 1 for every defined operation except CMP and BIT. The undefined code 15 gives `writeEn`=0 and leaves the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 16 | First operand; destination value |
| opB | input | 16 | Second operand; source value |
| opCode | input | 4 | Operation select (R1) |
| byteMode | input | 1 | 1 = byte size, 0 = word size |
| statusIn | input | 16 | Current status word |
| condCode | input | 3 | Jump condition select (R12) |
| result | output | 16 | Operation result |
| writeEn | output | 1 | Result should be written to the destination |
| statusOut | output | 16 | Status word after the flag merge |
| jumpTaken | output | 1 | Jump condition holds on `statusIn` |

## Verification
The assertions check structural rules on every evaluation. They check that non-flag status bits pass through, and that the write-enable matches the operation class. They check that the flag-neutral operations leave the status word untouched, that the upper byte is clear in byte mode, and that N and Z agree with the result for every flag-updating operation. Some behaviours can only be shown by the bench's scenarios against its reference model: the arithmetic values, the carry and overflow, the decimal correction across digits, and the rotate-through-carry behaviour. The bench drives seeded random vectors and adds directed edges: signed overflow at both sizes, decimal wrap at 99 and 9999, and an exhaustive sweep of jump conditions over all flag combinations.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ADDC = 4'd1,  OP_SUB  = 4'd2,  OP_SUBC = 4'd3,
    OP_CMP  = 4'd4,  OP_DADD = 4'd5,  OP_AND  = 4'd6,  OP_BIT  = 4'd7,
    OP_BIC  = 4'd8,  OP_BIS  = 4'd9,  OP_XOR  = 4'd10, OP_RRC  = 4'd11,
    OP_RRA  = 4'd12, OP_SWPB = 4'd13, OP_SXT  = 4'd14, OP_NONE = 4'd15
  } alu_op_e;

  typedef enum logic [3:0] {
    FN_ADD, FN_DADD, FN_AND, FN_BIC, FN_BIS, FN_XOR,
    FN_RRC, FN_RRA, FN_SWPB, FN_SXT
  } alu_fn_e;

  typedef enum logic [1:0] {
    CIN_ZERO, CIN_ONE, CIN_FLAG
  } cin_sel_e;

  localparam int C_BIT = 0;
  localparam int Z_BIT = 1;
  localparam int N_BIT = 2;
  localparam int V_BIT = 8;

  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
  } flag_t;

  typedef struct packed {
    alu_fn_e  fn;
    logic     invertB;
    cin_sel_e cinSel;
    logic     forceWord;
    logic     writeEn;
    flag_t    flagMask;
  } alu_strobe_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [3:0]  opCode,
  output alu_strobe_t strobe
);

  localparam flag_t ALL_FLAGS = '{v: 1'b1, n: 1'b1, z: 1'b1, c: 1'b1};
  localparam flag_t NO_FLAGS  = '{v: 1'b0, n: 1'b0, z: 1'b0, c: 1'b0};
  localparam flag_t CZN_FLAGS = '{v: 1'b0, n: 1'b1, z: 1'b1, c: 1'b1};

  alu_op_e op;
  assign op = alu_op_e'(opCode);

  always_comb begin
    strobe.fn        = FN_ADD;
    strobe.invertB   = 1'b0;
    strobe.cinSel    = CIN_ZERO;
    strobe.forceWord = 1'b0;
    strobe.writeEn   = 1'b1;
    strobe.flagMask  = ALL_FLAGS;
    case (op)
      OP_ADD:  ;
      OP_ADDC: strobe.cinSel = CIN_FLAG;
      OP_SUB: begin
        strobe.invertB = 1'b1;
        strobe.cinSel  = CIN_ONE;
      end
      OP_SUBC: begin
        strobe.invertB = 1'b1;
        strobe.cinSel  = CIN_FLAG;
      end
      OP_CMP: begin
        strobe.invertB = 1'b1;
        strobe.cinSel  = CIN_ONE;
        strobe.writeEn = 1'b0;
      end
      OP_DADD: begin
        strobe.fn       = FN_DADD;
        strobe.cinSel   = CIN_FLAG;
        strobe.flagMask = CZN_FLAGS;
      end
      OP_AND:  strobe.fn = FN_AND;
      OP_BIT: begin
        strobe.fn      = FN_AND;
        strobe.writeEn = 1'b0;
      end
      OP_BIC: begin
        strobe.fn       = FN_BIC;
        strobe.flagMask = NO_FLAGS;
      end
      OP_BIS: begin
        strobe.fn       = FN_BIS;
        strobe.flagMask = NO_FLAGS;
      end
      OP_XOR:  strobe.fn = FN_XOR;
      OP_RRC: begin
        strobe.fn     = FN_RRC;
        strobe.cinSel = CIN_FLAG;
      end
      OP_RRA:  strobe.fn = FN_RRA;
      OP_SWPB: begin
        strobe.fn        = FN_SWPB;
        strobe.forceWord = 1'b1;
        strobe.flagMask  = NO_FLAGS;
      end
      OP_SXT: begin
        strobe.fn        = FN_SXT;
        strobe.forceWord = 1'b1;
      end
      default: begin
        strobe.writeEn  = 1'b0;
        strobe.flagMask = NO_FLAGS;
      end
    endcase
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              byteMode,
  input  logic              carryFlag,
  input  alu_strobe_t       strobe,
  output logic [DATA_W-1:0] result,
  output flag_t             newFlags
);

  localparam int BYTE_W = DATA_W / 2;
  localparam int DIGITS = DATA_W / 4;

  logic              wordSel;
  logic [DATA_W-1:0] sizeMask, msbMask;
  logic [DATA_W-1:0] aM, bM, bEff;
  logic              cin;
  logic [DATA_W:0]   sumWide;
  logic              addCarry;
  logic              signA, signB, signR;
  logic [DATA_W-1:0] res;

  assign wordSel  = strobe.forceWord | ~byteMode;
  assign sizeMask = wordSel ? {DATA_W{1'b1}} : {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};
  assign msbMask  = wordSel ? (DATA_W'(1) << (DATA_W-1)) : (DATA_W'(1) << (BYTE_W-1));
  assign aM       = opA & sizeMask;
  assign bM       = opB & sizeMask;
  assign bEff     = (strobe.invertB ? ~opB : opB) & sizeMask;

  always_comb begin
    case (strobe.cinSel)
      CIN_ONE:  cin = 1'b1;
      CIN_FLAG: cin = carryFlag;
      default:  cin = 1'b0;
    endcase
  end

  // Binary adder shared by add, subtract and compare
  assign sumWide  = {1'b0, aM} + {1'b0, bEff} + (DATA_W+1)'(cin);
  assign addCarry = wordSel ? sumWide[DATA_W] : sumWide[BYTE_W];

  // Decimal adder: a chain of per-digit adders with correction
  logic [DIGITS:0]   digCarry;
  logic [DATA_W-1:0] bcdSum;
  logic              decCarry;
  assign digCarry[0] = cin;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    logic [4:0] raw;
    assign raw = {1'b0, aM[4*d +: 4]} + {1'b0, bM[4*d +: 4]} + 5'(digCarry[d]);
    assign digCarry[d+1]  = (raw > 5'd9);
    assign bcdSum[4*d +: 4] = (raw > 5'd9) ? 4'(raw - 5'd10) : raw[3:0];
  end

  assign decCarry = wordSel ? digCarry[DIGITS] : digCarry[DIGITS/2];

  always_comb begin
    case (strobe.fn)
      FN_ADD:  res = sumWide[DATA_W-1:0];
      FN_DADD: res = bcdSum;
      FN_AND:  res = aM & bM;
      FN_BIC:  res = aM & ~bM;
      FN_BIS:  res = aM | bM;
      FN_XOR:  res = aM ^ bM;
      FN_RRC:  res = (aM >> 1) | (carryFlag ? msbMask : '0);
      FN_RRA:  res = (aM >> 1) | (aM & msbMask);
      FN_SWPB: res = {opA[BYTE_W-1:0], opA[DATA_W-1:BYTE_W]};
      FN_SXT:  res = {{BYTE_W{opA[BYTE_W-1]}}, opA[BYTE_W-1:0]};
      default: res = '0;
    endcase
    result = res & sizeMask;
  end

  assign signA = |(aM & msbMask);
  assign signB = |(bEff & msbMask);
  assign signR = |(result & msbMask);

  always_comb begin
    newFlags.n = signR;
    newFlags.z = (result == '0);
    newFlags.c = (result != '0);
    newFlags.v = 1'b0;
    case (strobe.fn)
      FN_ADD: begin
        newFlags.c = addCarry;
        newFlags.v = (signA == signB) && (signR != signA);
      end
      FN_DADD: newFlags.c = decCarry;
      FN_XOR:  newFlags.v = signA && (|(bM & msbMask));
      FN_RRC, FN_RRA: newFlags.c = opA[0];
      default: ;
    endcase
  end

endmodule

// File: rtl/alu_status.sv
module alu_status
  import alu_pkg::*;
#(
  parameter int SR_W = 16
) (
  input  logic [SR_W-1:0] statusIn,
  input  flag_t           newFlags,
  input  flag_t           flagMask,
  input  logic [2:0]      condCode,
  output logic [SR_W-1:0] statusOut,
  output logic            jumpTaken
);

  logic [SR_W-1:0] maskVec, flagVec;

  always_comb begin
    maskVec = '0;
    flagVec = '0;
    maskVec[C_BIT] = flagMask.c;
    maskVec[Z_BIT] = flagMask.z;
    maskVec[N_BIT] = flagMask.n;
    maskVec[V_BIT] = flagMask.v;
    flagVec[C_BIT] = newFlags.c;
    flagVec[Z_BIT] = newFlags.z;
    flagVec[N_BIT] = newFlags.n;
    flagVec[V_BIT] = newFlags.v;
    statusOut = (statusIn & ~maskVec) | (flagVec & maskVec);
  end

  logic curC, curZ, curN, curV;
  assign curC = statusIn[C_BIT];
  assign curZ = statusIn[Z_BIT];
  assign curN = statusIn[N_BIT];
  assign curV = statusIn[V_BIT];

  always_comb begin
    case (condCode)
      3'd0:    jumpTaken = ~curZ;
      3'd1:    jumpTaken = curZ;
      3'd2:    jumpTaken = ~curC;
      3'd3:    jumpTaken = curC;
      3'd4:    jumpTaken = curN;
      3'd5:    jumpTaken = (curN == curV);
      3'd6:    jumpTaken = (curN != curV);
      default: jumpTaken = 1'b1;
    endcase
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SR_W   = 16
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [3:0]        opCode,
  input  logic              byteMode,
  input  logic [SR_W-1:0]   statusIn,
  input  logic [2:0]        condCode,
  output logic [DATA_W-1:0] result,
  output logic              writeEn,
  output logic [SR_W-1:0]   statusOut,
  output logic              jumpTaken
);

  alu_strobe_t strobe;
  flag_t       newFlags;

  alu_ctrl u_ctrl (
    .opCode (opCode),
    .strobe (strobe)
  );

  alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .opA       (opA),
    .opB       (opB),
    .byteMode  (byteMode),
    .carryFlag (statusIn[C_BIT]),
    .strobe    (strobe),
    .result    (result),
    .newFlags  (newFlags)
  );

  alu_status #(.SR_W(SR_W)) u_status (
    .statusIn  (statusIn),
    .newFlags  (newFlags),
    .flagMask  (strobe.flagMask),
    .condCode  (condCode),
    .statusOut (statusOut),
    .jumpTaken (jumpTaken)
  );

  assign writeEn = strobe.writeEn;

endmodule

// File: rtl/alu_core_checker.sv
module alu_core_checker #(
  parameter int DATA_W = 16,
  parameter int SR_W   = 16
) (
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [3:0]        opCode,
  input logic              byteMode,
  input logic [SR_W-1:0]   statusIn,
  input logic [2:0]        condCode,
  input logic [DATA_W-1:0] result,
  input logic              writeEn,
  input logic [SR_W-1:0]   statusOut,
  input logic              jumpTaken
);

  localparam int BYTE_W = DATA_W / 2;
  localparam logic [SR_W-1:0] FLAG_POS = SR_W'(16'h0107);

  logic noWrite, flagNeutral, wordOnly, updatesNz, byteSized;
  logic [DATA_W-1:0] chkMask;
  logic chkMsb;

  always_comb begin
    noWrite     = (opCode == 4'd4) || (opCode == 4'd7) || (opCode == 4'd15);
    flagNeutral = (opCode == 4'd8) || (opCode == 4'd9) || (opCode == 4'd13) || (opCode == 4'd15);
    wordOnly    = (opCode == 4'd13) || (opCode == 4'd14);
    updatesNz   = !flagNeutral;
    byteSized   = byteMode && !wordOnly;
    chkMask     = byteSized ? DATA_W'({BYTE_W{1'b1}}) : {DATA_W{1'b1}};
    chkMsb      = byteSized ? result[BYTE_W-1] : result[DATA_W-1];

    // R1: bits outside the flag positions pass through
    assert_reserved_pass_R1: assert ((statusOut & ~FLAG_POS) == (statusIn & ~FLAG_POS))
      else $error("reserved status bits changed");
    // R13: write enable by operation class
    assert_write_enable_R13: assert (writeEn == !noWrite)
      else $error("writeEn mismatch for opcode %0d", opCode);
    // R8: flag-neutral operations leave status untouched
    assert_flags_held_R8: assert (!flagNeutral || (statusOut == statusIn))
      else $error("status changed by flag-neutral opcode %0d", opCode);
    // R11: byte results have a clear upper byte
    assert_byte_upper_zero_R11: assert (!byteSized || (result[DATA_W-1:BYTE_W] == '0))
      else $error("upper byte not clear in byte mode");
    // R4: N follows the result sign
    assert_n_flag_R4: assert (!updatesNz || (statusOut[2] == chkMsb))
      else $error("N flag disagrees with result");
    // R4: Z follows the result being zero
    assert_z_flag_R4: assert (!updatesNz || (statusOut[1] == ((result & chkMask) == '0)))
      else $error("Z flag disagrees with result");
    // R12: always-taken and equal conditions
    assert_jump_eq_R12: assert ((condCode != 3'd1) || (jumpTaken == statusIn[1]))
      else $error("EQ condition mismatch");
    assert_jump_always_R12: assert ((condCode != 3'd7) || jumpTaken)
      else $error("always condition not taken");
  end

endmodule

bind alu_core alu_core_checker #(.DATA_W(DATA_W), .SR_W(SR_W)) u_chk (
  .opA       (opA),
  .opB       (opB),
  .opCode    (opCode),
  .byteMode  (byteMode),
  .statusIn  (statusIn),
  .condCode  (condCode),
  .result    (result),
  .writeEn   (writeEn),
  .statusOut (statusOut),
  .jumpTaken (jumpTaken)
);

// File: tb/sim_alu_core.sv
module sim_alu_core;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic [3:0]  opCode = '0;
  logic        byteMode = 1'b0;
  logic [15:0] statusIn = '0;
  logic [2:0]  condCode = '0;
  logic [15:0] result;
  logic        writeEn;
  logic [15:0] statusOut;
  logic        jumpTaken;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  alu_core u0 (
    .opA(opA), .opB(opB), .opCode(opCode), .byteMode(byteMode),
    .statusIn(statusIn), .condCode(condCode), .result(result),
    .writeEn(writeEn), .statusOut(statusOut), .jumpTaken(jumpTaken)
  );

  typedef struct packed {
    logic [15:0] res;
    logic        we;
    logic [15:0] sr;
  } exp_t;

  function automatic string opTag(input logic [3:0] op);
    case (op)
      0, 1:        return "R2";
      2, 3, 4:     return "R3";
      5:           return "R5";
      6, 7:        return "R6";
      10:          return "R7";
      8, 9:        return "R8";
      11, 12:      return "R9";
      13, 14:      return "R10";
      default:     return "R13";
    endcase
  endfunction

  function automatic exp_t model(input logic [15:0] a0, input logic [15:0] b0,
                                 input logic [3:0] op, input logic bm,
                                 input logic [15:0] sr);
    exp_t e;
    int w, mask, sgn, a, b, r, nb, full, cy, s;
    logic c, v, fc, fz, fn, fv;
    w    = (bm && op != 13 && op != 14) ? 8 : 16;
    mask = (1 << w) - 1;
    sgn  = 1 << (w - 1);
    a = int'(a0) & mask;
    b = int'(b0) & mask;
    r = 0; c = 0; v = 0;
    fc = 1; fz = 1; fn = 1; fv = 1;
    case (op)
      0, 1, 2, 3, 4: begin
        nb = (op >= 2) ? ((~b) & mask) : b;
        cy = (op == 0) ? 0 : ((op == 2 || op == 4) ? 1 : int'(sr[0]));
        full = a + nb + cy;
        r = full & mask;
        c = ((full >> w) & 1) != 0;
        v = ((a & sgn) == (nb & sgn)) && ((r & sgn) != (a & sgn));
      end
      5: begin
        cy = int'(sr[0]);
        for (int d = 0; d < w / 4; d++) begin
          s = ((a >> (4 * d)) & 15) + ((b >> (4 * d)) & 15) + cy;
          if (s > 9) begin s = s - 10; cy = 1; end else cy = 0;
          r = r | (s << (4 * d));
        end
        c = (cy != 0);
        fv = 0;
      end
      6, 7: begin r = a & b; c = (r != 0); end
      8: begin r = a & ~b & mask; fc = 0; fz = 0; fn = 0; fv = 0; end
      9: begin r = a | b; fc = 0; fz = 0; fn = 0; fv = 0; end
      10: begin
        r = a ^ b; c = (r != 0);
        v = ((a & sgn) != 0) && ((b & sgn) != 0);
      end
      11: begin r = (a >> 1) | (sr[0] ? sgn : 0); c = (a & 1) != 0; end
      12: begin r = (a >> 1) | (a & sgn); c = (a & 1) != 0; end
      13: begin
        r = ((a & 255) << 8) | ((a >> 8) & 255);
        fc = 0; fz = 0; fn = 0; fv = 0;
      end
      14: begin
        r = ((a & 128) != 0) ? ((a | 'hFF00) & 'hFFFF) : (a & 255);
        c = (r != 0);
      end
      default: begin fc = 0; fz = 0; fn = 0; fv = 0; end
    endcase
    e.res = 16'(r);
    e.we  = !(op == 4 || op == 7 || op == 15);
    e.sr  = sr;
    if (fc) e.sr[0] = c;
    if (fz) e.sr[1] = ((r & mask) == 0);
    if (fn) e.sr[2] = ((r & sgn) != 0);
    if (fv) e.sr[8] = v;
    return e;
  endfunction

  function automatic logic jumpModel(input logic [15:0] sr, input logic [2:0] cc);
    case (cc)
      0: return !sr[1];
      1: return sr[1];
      2: return !sr[0];
      3: return sr[0];
      4: return sr[2];
      5: return sr[2] == sr[8];
      6: return sr[2] != sr[8];
      default: return 1'b1;
    endcase
  endfunction

  task automatic applyCheck(input logic [15:0] a, input logic [15:0] b,
                            input logic [3:0] op, input logic bm,
                            input logic [15:0] sr, input logic [2:0] cc,
                            input string what);
    exp_t e;
    logic ej;
    @(negedge clk);
    opA = a; opB = b; opCode = op; byteMode = bm; statusIn = sr; condCode = cc;
    #(CLK_PERIOD/4);
    e  = model(a, b, op, bm, sr);
    ej = jumpModel(sr, cc);
    if (op != 4'd15) begin
      checks++;
      if (result !== e.res) begin
        errors++;
        $display("FAIL %s %s result: op=%0d a=%h b=%h bm=%0b actual=%h expected=%h",
                 opTag(op), what, op, a, b, bm, result, e.res);
      end
    end
    checks++;
    if (writeEn !== e.we) begin
      errors++;
      $display("FAIL R13 %s writeEn: op=%0d actual=%0b expected=%0b", what, op, writeEn, e.we);
    end
    checks++;
    if (statusOut !== e.sr) begin
      errors++;
      $display("FAIL %s %s status: op=%0d a=%h b=%h bm=%0b sr=%h actual=%h expected=%h",
               opTag(op), what, op, a, b, bm, sr, statusOut, e.sr);
    end
    checks++;
    if (jumpTaken !== ej) begin
      errors++;
      $display("FAIL R12 %s jump: cc=%0d sr=%h actual=%0b expected=%0b",
               what, cc, sr, jumpTaken, ej);
    end
  endtask

  function automatic logic [15:0] randBcd();
    logic [15:0] v;
    for (int d = 0; d < 4; d++) v[4*d +: 4] = 4'($urandom % 10);
    return v;
  endfunction

  initial begin
    void'($urandom(32'h5EED_0A1C));
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // Reset-time state: all-zero inputs, R1 status layout and R4 zero flag
    applyCheck(16'h0000, 16'h0000, 4'd0, 1'b0, 16'h0000, 3'd0, "reset R1 R4");
    // R1 reserved bits pass through
    applyCheck(16'h1234, 16'h4321, 4'd0, 1'b0, 16'hFEF8, 3'd7, "reserved R1");
    // R2 signed overflow at word and byte size
    applyCheck(16'h7FFF, 16'h0001, 4'd0, 1'b0, 16'h0000, 3'd5, "word ovf R2");
    applyCheck(16'h347F, 16'h0001, 4'd0, 1'b1, 16'h0000, 3'd6, "byte ovf R2 R11");
    applyCheck(16'h00FF, 16'h0001, 4'd1, 1'b1, 16'h0001, 3'd1, "byte carry R2");
    applyCheck(16'hFFFF, 16'h0000, 4'd1, 1'b0, 16'h0001, 3'd3, "addc wrap R2");
    // R3 subtract and compare
    applyCheck(16'h0005, 16'h0005, 4'd2, 1'b0, 16'h0000, 3'd1, "sub equal R3");
    applyCheck(16'h8000, 16'h0001, 4'd2, 1'b0, 16'h0000, 3'd2, "sub ovf R3");
    applyCheck(16'h0003, 16'h0005, 4'd4, 1'b0, 16'h0000, 3'd4, "cmp R3");
    applyCheck(16'h0010, 16'h0010, 4'd3, 1'b1, 16'h0000, 3'd2, "subc borrow R3");
    // R5 decimal add wraps
    applyCheck(16'h9999, 16'h0001, 4'd5, 1'b0, 16'h0000, 3'd3, "dadd 9999 R5");
    applyCheck(16'h1299, 16'h0000, 4'd5, 1'b1, 16'h0101, 3'd3, "dadd 99 R5");
    applyCheck(16'h0458, 16'h0367, 4'd5, 1'b0, 16'h0000, 3'd0, "dadd chain R5");
    // R6 and/bit
    applyCheck(16'hF0F0, 16'h0F0F, 4'd6, 1'b0, 16'h0100, 3'd2, "and zero R6");
    applyCheck(16'h8001, 16'h8000, 4'd7, 1'b0, 16'h0000, 3'd4, "bit R6");
    // R7 xor overflow
    applyCheck(16'h8000, 16'h8000, 4'd10, 1'b0, 16'h0000, 3'd5, "xor neg R7");
    applyCheck(16'h0080, 16'h00C0, 4'd10, 1'b1, 16'h0000, 3'd6, "xor byte R7");
    // R8 bic/bis keep flags
    applyCheck(16'hFFFF, 16'h00FF, 4'd8, 1'b0, 16'h0107, 3'd0, "bic R8");
    applyCheck(16'h1200, 16'h0034, 4'd9, 1'b1, 16'h0102, 3'd1, "bis R8 R11");
    // R9 rotates
    applyCheck(16'h0001, 16'h0000, 4'd11, 1'b0, 16'h0001, 3'd3, "rrc word R9");
    applyCheck(16'h0081, 16'h0000, 4'd11, 1'b1, 16'h0000, 3'd3, "rrc byte R9");
    applyCheck(16'h8002, 16'h0000, 4'd12, 1'b0, 16'h0100, 3'd4, "rra word R9");
    applyCheck(16'h0085, 16'h0000, 4'd12, 1'b1, 16'h0000, 3'd4, "rra byte R9");
    // R10 word-only ops in byte mode
    applyCheck(16'h12AB, 16'h0000, 4'd13, 1'b1, 16'h0105, 3'd0, "swpb R10");
    applyCheck(16'h1280, 16'h0000, 4'd14, 1'b1, 16'h0000, 3'd4, "sxt neg R10");
    applyCheck(16'hFF00, 16'h0000, 4'd14, 1'b0, 16'h0101, 3'd1, "sxt zero R10");
    // R13 undefined code
    applyCheck(16'hAAAA, 16'h5555, 4'd15, 1'b0, 16'h0107, 3'd7, "undef R13");

    // R12 exhaustive conditions over flag combinations
    for (int f = 0; f < 16; f++) begin
      for (int cc = 0; cc < 8; cc++) begin
        logic [15:0] sr;
        sr = 16'h0000;
        sr[0] = f[0]; sr[1] = f[1]; sr[2] = f[2]; sr[8] = f[3];
        applyCheck(16'h0000, 16'h0000, 4'd9, 1'b0, sr, 3'(cc), "cond sweep R12");
      end
    end

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [3:0]  op;
      logic [15:0] a, b, sr;
      op = 4'($urandom % 16);
      a  = 16'($urandom);
      b  = 16'($urandom);
      sr = 16'($urandom);
      if (op == 4'd5) begin
        a = randBcd();
        b = randBcd();
      end
      applyCheck(a, b, op, 1'($urandom), sr, 3'($urandom), "random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired before the scenarios completed");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule